// File: doc/BRIEF.md
# Windowed Low-Power Watchdog Timer

This block is a watchdog that counts edges of a slow, always-running low-power clock. A fixed prescaler divides that clock by one of two powers of two, and a postscaler divides the prescaler ticks by a further power of two that software selects. If software does not clear the counters before the selected period ends, the block raises a one-cycle reset request. When the system is asleep or idle, the same time-out raises a one-cycle wake request instead.

The counters restart from zero on every accepted clear. They also restart on a finished clock switch, on entry into a low-power state, on exit from one, and after each time-out. An optional window mode treats a clear that arrives too early as a fault. A sticky flag records every watchdog event until software clears it.

The watchdog runs whenever the hard enable strap is high. Otherwise it runs only while a software enable bit is set. All signals are in the watchdog clock domain. The short prescaler setting must divide by at least 4 (`PRE_SHORT_LOG2` >= 2).

Top module: `wdt_window_top`

## Requirements
- R1: `pre_sel`=0 divides the clock by 2^`PRE_SHORT_LOG2` and `pre_sel`=1 divides it by 2^`PRE_LONG_LOG2`. With the defaults these are 32 and 128; with the bench override of 2 and 3 they are 4 and 8.
- R2: The time-out period is (prescaler divide) × 2^`post_sel` clocks, for `post_sel` 0 to 15. A time-out outside low power gives a one-cycle `wdt_rst` pulse in the cycle after the period ends, and the counters restart from zero.
- R3: While running, a pulse on `clr` (when accepted), `clk_sw_done`, `lp_enter` or `lp_exit` restarts the counters from zero at the edge that samples it, so a full period then elapses before a time-out.
- R4: With `hw_en`=1 the watchdog always runs, whatever the software enable bit holds.
- R5: With `hw_en`=0 the watchdog runs only while the software enable bit is 1. That bit is loaded from `sw_en_wd` at each edge where `sw_en_we`=1. Counting starts from zero at the edge that sets it.
- R6: While disabled, the counters are held at zero and no `clr` or event strobe produces a `wdt_rst` or `wdt_wake` pulse.
- R7: A time-out while `in_lowpower`=1 gives a one-cycle `wdt_wake` pulse and no `wdt_rst`. `wdt_rst` and `wdt_wake` are never high together.
- R8: With `win_dis`=0, a `clr` sampled while the elapsed count is below three quarters of the period gives a `wdt_rst` pulse in the next cycle, sets the flag and restarts the counters. For a period of 16 clocks, a clear at elapsed count 11 is early.
- R9: With `win_dis`=0, a `clr` sampled at an elapsed count of three quarters of the period or more restarts the counters without any pulse. For 16 clocks, this applies from elapsed count 12.
- R10: `to_flag` is set by every `wdt_rst` or `wdt_wake` pulse and stays set until a cycle with `flag_clr`=1 and no new event. A new event wins over `flag_clr`.
- R11: With `win_dis`=1, a `clr` at any elapsed count restarts the counters without any pulse.
- R12: `rst` clears the counters, the software enable bit, `to_flag`, `wdt_rst` and `wdt_wake`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-power watchdog clock |
| rst | input | 1 | Synchronous active-high system reset |
| hw_en | input | 1 | Hard enable strap; forces the watchdog on |
| sw_en_we | input | 1 | Write strobe for the software enable bit |
| sw_en_wd | input | 1 | Value written to the software enable bit |
| pre_sel | input | 1 | Prescaler select: 0 short divide, 1 long divide |
| post_sel | input | POST_SEL_W | Postscaler exponent |
| win_dis | input | 1 | 1 disables window mode |
| clr | input | 1 | Software clear strobe |
| clk_sw_done | input | 1 | Clock switch completed strobe |
| lp_enter | input | 1 | Low-power entry strobe |
| lp_exit | input | 1 | Low-power exit strobe |
| in_lowpower | input | 1 | System is in sleep or idle |
| flag_clr | input | 1 | Software clear of the time-out flag |
| wdt_rst | output | 1 | One-cycle reset request |
| wdt_wake | output | 1 | One-cycle wake request |
| to_flag | output | 1 | Sticky watchdog event flag |

## Verification
The bench tests both sides of the window boundary: elapsed counts 11 and 12 for a 16-clock period. A comparator off by one count or off by one quarter would reset on a legal clear or let an early one pass. It measures periods at several prescaler and postscaler pairs, and measures a second period after each time-out, so an off-by-one terminal count or a counter that does not restart gives a wrong cycle count. Strobes sent to a disabled watchdog must produce nothing. A sleep time-out must produce a wake pulse rather than a reset. The flag must survive quiet cycles and then respond to its clear.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {
    PRE_SHORT = 1'b0,
    PRE_LONG  = 1'b1
  } pre_mode_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int SHORT_LOG2 = 5,
  parameter int LONG_LOG2  = 7
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   run,
  input  logic                   restart,
  input  wdt_pkg::pre_mode_e     mode,
  output logic [LONG_LOG2-1:0]   cnt,
  output logic                   tick
);
  localparam logic [LONG_LOG2-1:0] LONG_LIMIT  = '1;
  localparam logic [LONG_LOG2-1:0] SHORT_LIMIT = LONG_LOG2'((64'd1 << SHORT_LOG2) - 64'd1);

  logic [LONG_LOG2-1:0] limit;

  assign limit = (mode == wdt_pkg::PRE_LONG) ? LONG_LIMIT : SHORT_LIMIT;
  assign tick  = run && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (run)       cnt <= tick ? '0 : cnt + 1'b1;
  end

  // R1: the prescaler wraps to zero after each tick
  p_pre_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (tick && !restart) |=> (cnt == '0));
endmodule

// File: rtl/wdt_postscaler.sv
module wdt_postscaler #(
  parameter int SEL_W = 4,
  parameter int CNT_W = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] cnt,
  output logic             terminal
);
  localparam int NSEL = 1 << SEL_W;

  logic [CNT_W-1:0] mask_tab [NSEL];

  for (genvar g = 0; g < NSEL; g++) begin : g_mask
    assign mask_tab[g] = CNT_W'((64'd1 << g) - 64'd1);
  end

  assign terminal = tick && (cnt == mask_tab[sel]);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (tick)      cnt <= terminal ? '0 : cnt + 1'b1;
  end

  // R2: the postscaler only moves on a prescaler tick or a restart
  p_post_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !restart) |=> $stable(cnt));
endmodule

// File: rtl/wdt_window.sv
module wdt_window #(
  parameter int SHORT_LOG2 = 5,
  parameter int LONG_LOG2  = 7,
  parameter int SEL_W      = 4,
  parameter int CNT_W      = (1 << SEL_W) - 1
) (
  input  wdt_pkg::pre_mode_e   mode,
  input  logic [SEL_W-1:0]     sel,
  input  logic [LONG_LOG2-1:0] pre_cnt,
  input  logic [CNT_W-1:0]     post_cnt,
  output logic                 open
);
  localparam int EW = CNT_W + LONG_LOG2;

  logic [5:0]    plog;
  logic [5:0]    sh;
  logic [EW-1:0] elapsed;
  logic [EW-1:0] thr;

  // elapsed clocks since restart, compared to 3/4 of the full period
  assign plog    = (mode == wdt_pkg::PRE_LONG) ? 6'(LONG_LOG2) : 6'(SHORT_LOG2);
  assign sh      = plog + 6'(sel) - 6'd2;
  assign elapsed = (EW'(post_cnt) << plog) | EW'(pre_cnt);
  assign thr     = EW'(3) << sh;
  assign open    = (elapsed >= thr);
endmodule

// File: rtl/wdt_window_top.sv
module wdt_window_top #(
  parameter int PRE_SHORT_LOG2 = 5,
  parameter int PRE_LONG_LOG2  = 7,
  parameter int POST_SEL_W     = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  hw_en,
  input  logic                  sw_en_we,
  input  logic                  sw_en_wd,
  input  logic                  pre_sel,
  input  logic [POST_SEL_W-1:0] post_sel,
  input  logic                  win_dis,
  input  logic                  clr,
  input  logic                  clk_sw_done,
  input  logic                  lp_enter,
  input  logic                  lp_exit,
  input  logic                  in_lowpower,
  input  logic                  flag_clr,
  output logic                  wdt_rst,
  output logic                  wdt_wake,
  output logic                  to_flag
);
  import wdt_pkg::*;

  localparam int POST_CNT_W = (1 << POST_SEL_W) - 1;

  logic                     sw_en_q;
  logic                     active;
  logic                     restart;
  logic                     tick;
  logic                     timeout;
  logic                     win_open;
  logic                     early;
  logic [PRE_LONG_LOG2-1:0] pre_cnt;
  logic [POST_CNT_W-1:0]    post_cnt;
  pre_mode_e                mode;

  assign mode   = pre_mode_e'(pre_sel);
  assign active = hw_en || sw_en_q;

  always_ff @(posedge clk) begin
    if (rst)           sw_en_q <= 1'b0;
    else if (sw_en_we) sw_en_q <= sw_en_wd;
  end

  assign early   = active && clr && !win_dis && !win_open;
  assign restart = !active || clr || clk_sw_done || lp_enter || lp_exit || timeout;

  wdt_prescaler #(
    .SHORT_LOG2 (PRE_SHORT_LOG2),
    .LONG_LOG2  (PRE_LONG_LOG2)
  ) u_pre (
    .clk     (clk),
    .rst     (rst),
    .run     (active),
    .restart (restart),
    .mode    (mode),
    .cnt     (pre_cnt),
    .tick    (tick)
  );

  wdt_postscaler #(
    .SEL_W (POST_SEL_W),
    .CNT_W (POST_CNT_W)
  ) u_post (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .restart  (restart),
    .sel      (post_sel),
    .cnt      (post_cnt),
    .terminal (timeout)
  );

  wdt_window #(
    .SHORT_LOG2 (PRE_SHORT_LOG2),
    .LONG_LOG2  (PRE_LONG_LOG2),
    .SEL_W      (POST_SEL_W),
    .CNT_W      (POST_CNT_W)
  ) u_win (
    .mode     (mode),
    .sel      (post_sel),
    .pre_cnt  (pre_cnt),
    .post_cnt (post_cnt),
    .open     (win_open)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wdt_rst  <= 1'b0;
      wdt_wake <= 1'b0;
      to_flag  <= 1'b0;
    end else begin
      wdt_rst  <= (timeout && !in_lowpower) || early;
      wdt_wake <= timeout && in_lowpower && !early;
      if (timeout || early) to_flag <= 1'b1;
      else if (flag_clr)    to_flag <= 1'b0;
    end
  end

  // R7: reset and wake requests never coincide
  p_pulse_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(wdt_rst && wdt_wake));

  // R7: no reset request from a sleeping system without a clear
  p_lp_no_rst_r7: assert property (@(posedge clk) disable iff (rst)
    (active && in_lowpower && !clr) |=> !wdt_rst);

  // R6: a disabled watchdog stays silent
  p_quiet_disabled_r6: assert property (@(posedge clk) disable iff (rst)
    !active |=> (!wdt_rst && !wdt_wake));

  // R8: an early clear in window mode always resets
  p_early_rst_r8: assert property (@(posedge clk) disable iff (rst)
    (active && clr && !win_dis && !win_open) |=> wdt_rst);

  // R10: flag holds until cleared
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (to_flag && !flag_clr) |=> to_flag);

  // R10: every request is recorded in the flag
  p_flag_on_event_r10: assert property (@(posedge clk) disable iff (rst)
    (wdt_rst || wdt_wake) |-> to_flag);
endmodule

// File: tb/wdt_window_top_tb.sv
`timescale 1ns/1ps
module wdt_window_top_tb;
  localparam int PS = 2;
  localparam int PL = 3;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hw_en = 1'b1;
  logic          sw_en_we = 1'b0;
  logic          sw_en_wd = 1'b0;
  logic          pre_sel = 1'b0;
  logic [SW-1:0] post_sel = '0;
  logic          win_dis = 1'b1;
  logic          clr = 1'b0;
  logic          clk_sw_done = 1'b0;
  logic          lp_enter = 1'b0;
  logic          lp_exit = 1'b0;
  logic          in_lowpower = 1'b0;
  logic          flag_clr = 1'b0;
  logic          wdt_rst;
  logic          wdt_wake;
  logic          to_flag;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  wdt_window_top #(
    .PRE_SHORT_LOG2 (PS),
    .PRE_LONG_LOG2  (PL),
    .POST_SEL_W     (SW)
  ) u_dut (
    .clk (clk), .rst (rst), .hw_en (hw_en), .sw_en_we (sw_en_we),
    .sw_en_wd (sw_en_wd), .pre_sel (pre_sel), .post_sel (post_sel),
    .win_dis (win_dis), .clr (clr), .clk_sw_done (clk_sw_done),
    .lp_enter (lp_enter), .lp_exit (lp_exit), .in_lowpower (in_lowpower),
    .flag_clr (flag_clr), .wdt_rst (wdt_rst), .wdt_wake (wdt_wake),
    .to_flag (to_flag)
  );

  // stimulus table: prescaler select, postscaler select, expected period
  localparam int NV = 6;
  localparam int VP [NV] = '{0, 1, 0, 1, 0, 1};
  localparam int VS [NV] = '{0, 0, 3, 2, 5, 4};
  localparam int VN [NV] = '{4, 8, 32, 32, 128, 128};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    step(3);
    check(!wdt_rst && !wdt_wake && !to_flag, "R12 outputs in reset",
          int'({wdt_rst, wdt_wake, to_flag}), 0);
    rst = 1'b0;
  endtask

  task automatic measure(output int n, output logic got_wake);
    n = 0;
    got_wake = 1'b0;
    for (int i = 1; i <= 5000; i++) begin
      @(negedge clk);
      if (wdt_rst || wdt_wake) begin
        n = i;
        got_wake = wdt_wake;
        break;
      end
    end
  endtask

  task automatic strobe_restart(input int which, input int at);
    int n;
    logic w;
    do_reset();
    step(at);
    case (which)
      0: clr = 1'b1;
      1: lp_enter = 1'b1;
      2: lp_exit = 1'b1;
      default: clk_sw_done = 1'b1;
    endcase
    step(1);
    clr = 1'b0; lp_enter = 1'b0; lp_exit = 1'b0; clk_sw_done = 1'b0;
    check(!wdt_rst, "R3 no pulse on restart strobe", int'(wdt_rst), 0);
    measure(n, w);
    check(n == 16 && !w, "R3 full period after restart strobe", n, 16);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n;
    logic w;
    int bad;

    // table walk: R1 and R2 periods and restart after time-out
    for (int i = 0; i < NV; i++) begin
      pre_sel  = VP[i][0];
      post_sel = SW'(VS[i]);
      do_reset();
      measure(n, w);
      check(n == VN[i] && !w, "R1 R2 first period", n, VN[i]);
      check(to_flag, "R10 flag after time-out", int'(to_flag), 1);
      measure(n, w);
      check(n == VN[i] && !w, "R2 period after restart", n, VN[i]);
    end

    pre_sel  = 1'b0;
    post_sel = SW'(2);

    // R8 early clear
    win_dis = 1'b0;
    do_reset();
    step(5);
    clr = 1'b1;
    step(1);
    clr = 1'b0;
    check(wdt_rst, "R8 early clear at 5", int'(wdt_rst), 1);
    check(to_flag, "R8 flag after early clear", int'(to_flag), 1);

    // R8 boundary: last count before window
    do_reset();
    step(11);
    clr = 1'b1;
    step(1);
    clr = 1'b0;
    check(wdt_rst, "R8 clear at 11", int'(wdt_rst), 1);

    // R9 first count inside window
    do_reset();
    step(12);
    clr = 1'b1;
    step(1);
    clr = 1'b0;
    check(!wdt_rst, "R9 clear at 12", int'(wdt_rst), 0);
    measure(n, w);
    check(n == 16 && !w, "R9 period after legal clear", n, 16);

    // R11 window disabled
    win_dis = 1'b1;
    do_reset();
    step(3);
    clr = 1'b1;
    step(1);
    clr = 1'b0;
    check(!wdt_rst, "R11 clear at 3 with window off", int'(wdt_rst), 0);
    measure(n, w);
    check(n == 16 && !w, "R11 period after clear", n, 16);

    // R3 other restart strobes
    strobe_restart(1, 10);
    strobe_restart(2, 7);
    strobe_restart(3, 9);

    // R7 wake in low power, R10 flag behaviour
    in_lowpower = 1'b1;
    do_reset();
    measure(n, w);
    check(n == 16 && w, "R7 wake period", n, 16);
    check(!wdt_rst, "R7 no reset in sleep", int'(wdt_rst), 0);
    in_lowpower = 1'b0;
    step(3);
    check(to_flag, "R10 flag sticky", int'(to_flag), 1);
    flag_clr = 1'b1;
    step(1);
    flag_clr = 1'b0;
    check(!to_flag, "R10 flag cleared", int'(to_flag), 0);

    // R6 disabled watchdog ignores everything
    hw_en = 1'b0;
    win_dis = 1'b0;
    do_reset();
    bad = 0;
    for (int i = 0; i < 200; i++) begin
      clr      = (i == 50);
      lp_enter = (i == 80);
      @(negedge clk);
      if (wdt_rst || wdt_wake) bad++;
    end
    clr = 1'b0;
    lp_enter = 1'b0;
    check(bad == 0, "R6 silent while disabled", bad, 0);

    // R5 software enable
    win_dis = 1'b1;
    sw_en_we = 1'b1;
    sw_en_wd = 1'b1;
    step(1);
    sw_en_we = 1'b0;
    measure(n, w);
    check(n == 16 && !w, "R5 period after software enable", n, 16);

    // R12 reset clears software enable
    do_reset();
    bad = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (wdt_rst || wdt_wake) bad++;
    end
    check(bad == 0, "R12 software enable cleared by reset", bad, 0);

    // R4 hard enable overrides software enable
    hw_en = 1'b1;
    do_reset();
    sw_en_we = 1'b1;
    sw_en_wd = 1'b0;
    step(1);
    sw_en_we = 1'b0;
    measure(n, w);
    check(n == 15 && !w, "R4 hard enable keeps running", n, 15);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule